// File: doc/BRIEF.md
# Drift-Free Fixed-Point Tick Timekeeper

This block keeps elapsed time as a binary fixed-point count of seconds. The time advances on every cycle where a tick strobe is high. The real tick duration usually has no exact value in that format. For example, a tenth of a second with eight fractional bits would be 25.6 units.

The block adds the truncated whole step on each tick. It also keeps the lost fraction as an integer remainder, measured against a denominator. When the remainder reaches the denominator, the time gets one extra least-significant unit and the denominator is taken off the remainder. The deviation from ideal time therefore stays below one unit forever and never grows. A one-cycle flag marks each tick that carried such a correction. The remainder is also exposed, so a consumer can tell when the time is exact: that is, when the remainder is zero.

Top module: `frac_time_accum`

## Requirements
- R1: While `rst_n` is low, `time_o`, `err_o` and `corr_o` are all zero, and they stay zero until the first tick after release.
- R2: On a clock edge with `tick_i` high, `time_o` becomes its old value plus `STEP`, plus one more unit when that tick corrects.
- R3: On a tick, let the sum be the old remainder plus `REM_INC`. If the sum is at least `DENOM`, `err_o` becomes the sum minus `DENOM`; otherwise `err_o` becomes the sum.
- R4: `corr_o` is high during the cycle after a tick whose remainder sum reached `DENOM`, and low during every other cycle.
- R5: On an edge with `tick_i` low, `time_o` and `err_o` keep their values and `corr_o` is low.
- R6: `err_o` is always below `DENOM`.
- R7: With the defaults (`STEP`=25, `REM_INC`=6, `DENOM`=10), four ticks from reset give time/remainder pairs 25/6, 51/2 (corrected), 76/8 and 102/4 (corrected).
- R8: `time_o` wraps modulo 2^`TIME_W` and never saturates.
- R9: After exactly `DENOM` ticks from reset, `time_o` equals `STEP*DENOM+REM_INC` and `err_o` is zero. With the defaults this is 256, which is one whole second.
- R10: Ticks on consecutive cycles are each counted, with no tick lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One elapsed tick period when high at an edge |
| time_o | output | TIME_W | Fixed-point elapsed time, FRAC_BITS fractional bits |
| err_o | output | $clog2(DENOM) | Remainder numerator, in units of 1/DENOM LSB |
| corr_o | output | 1 | High for the cycle after a tick that added the extra unit |

## Verification
Two events can fall on the same tick: the correction unit being added, and the time register wrapping past its top. With a 32-bit time, that coincidence is out of reach, so a second instance with an 8-bit time runs from the same tick strobe. On its tenth tick from reset, 230 + 25 + 1 must come out as 0 with the flag high. The scoreboard compares both instances against a model on every tick, and also checks that idle cycles leave everything unchanged.

// File: rtl/ftacc_pkg.sv
package ftacc_pkg;

    // Bits needed to hold a remainder in [0, denom-1]; denom must be >= 2.
    function automatic int rem_width(input int denom);
        return (denom < 2) ? 1 : $clog2(denom);
    endfunction

    // Remainder sum before the wrap check is below 2*denom, so one more bit.
    function automatic int sum_width(input int denom);
        return rem_width(denom) + 1;
    endfunction

endpackage

// File: rtl/ftacc_rem_unit.sv
// Remainder stage: adds the fractional increment and reports the carry.
module ftacc_rem_unit #(
    parameter int DENOM   = 10,
    parameter int REM_INC = 6,
    localparam int ERR_W  = ftacc_pkg::rem_width(DENOM),
    localparam int SUM_W  = ftacc_pkg::sum_width(DENOM)
) (
    input  logic [ERR_W-1:0] err_q,
    output logic [ERR_W-1:0] err_d,
    output logic             carry
);

    generate
        if (REM_INC == 0) begin : g_exact
            // Step is exactly representable: remainder never moves.
            assign err_d = err_q;
            assign carry = 1'b0;
        end else begin : g_frac
            logic [SUM_W-1:0] sum;
            always_comb begin
                sum   = {1'b0, err_q} + SUM_W'(REM_INC);
                carry = (sum >= SUM_W'(DENOM));
                if (carry) begin
                    err_d = ERR_W'(sum - SUM_W'(DENOM));
                end else begin
                    err_d = sum[ERR_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ftacc_time_unit.sv
// Time stage: adds the truncated step plus the optional correction unit.
module ftacc_time_unit #(
    parameter int TIME_W = 32,
    parameter int STEP   = 25
) (
    input  logic [TIME_W-1:0] time_q,
    input  logic              carry,
    output logic [TIME_W-1:0] time_d
);

    always_comb begin
        time_d = time_q + TIME_W'(STEP) + {{(TIME_W-1){1'b0}}, carry};
    end

endmodule

// File: rtl/frac_time_accum.sv
// Fixed-point time accumulator with bounded-error remainder correction.
module frac_time_accum #(
    parameter int TIME_W    = 32,
    parameter int FRAC_BITS = 8,
    parameter int STEP      = 25,
    parameter int REM_INC   = 6,
    parameter int DENOM     = 10,
    localparam int ERR_W    = ftacc_pkg::rem_width(DENOM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic [TIME_W-1:0] time_o,
    output logic [ERR_W-1:0]  err_o,
    output logic              corr_o
);

    // FRAC_BITS only fixes the meaning of time_o (one second = 2**FRAC_BITS).
    localparam int ONE_SEC = 1 << FRAC_BITS;

    typedef struct packed {
        logic [TIME_W-1:0] tm;
        logic [ERR_W-1:0]  er;
        logic              corr;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [ERR_W-1:0]  err_nx;
    logic              carry_nx;
    logic [TIME_W-1:0] time_nx;

    ftacc_rem_unit #(
        .DENOM   (DENOM),
        .REM_INC (REM_INC)
    ) u_rem (
        .err_q (st_q.er),
        .err_d (err_nx),
        .carry (carry_nx)
    );

    ftacc_time_unit #(
        .TIME_W (TIME_W),
        .STEP   (STEP)
    ) u_time (
        .time_q (st_q.tm),
        .carry  (carry_nx),
        .time_d (time_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.corr = 1'b0;
        if (tick_i) begin
            st_d.tm   = time_nx;
            st_d.er   = err_nx;
            st_d.corr = carry_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.tm;
    assign err_o  = st_q.er;
    assign corr_o = st_q.corr;

    logic unused_one_sec;
    assign unused_one_sec = ^ONE_SEC;

endmodule

// File: rtl/ftacc_checker.sv
module ftacc_checker #(
    parameter int TIME_W  = 32,
    parameter int STEP    = 25,
    parameter int REM_INC = 6,
    parameter int DENOM   = 10,
    localparam int ERR_W  = ftacc_pkg::rem_width(DENOM)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [TIME_W-1:0] time_o,
    input logic [ERR_W-1:0]  err_o,
    input logic              corr_o
);

    // R6
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(err_o) < DENOM);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(time_o) && $stable(err_o) && !corr_o));

    // R3
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (int'(err_o) == ((int'($past(err_o)) + REM_INC) % DENOM)));

    // R4
    corr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (corr_o == ((int'($past(err_o)) + REM_INC) >= DENOM)));

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (time_o == TIME_W'($past(time_o) + TIME_W'(STEP)
                                      + TIME_W'(corr_o))));

endmodule

bind frac_time_accum ftacc_checker #(
    .TIME_W  (TIME_W),
    .STEP    (STEP),
    .REM_INC (REM_INC),
    .DENOM   (DENOM)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .time_o (time_o),
    .err_o  (err_o),
    .corr_o (corr_o)
);

// File: tb/sim_frac_time_accum.sv
module sim_frac_time_accum;

    localparam int CLK_PERIOD = 10;
    localparam int STEP    = 25;
    localparam int REM_INC = 6;
    localparam int DENOM   = 10;
    localparam int ERR_W   = ftacc_pkg::rem_width(DENOM);

    typedef struct {
        longint t;
        int     e;
        bit     c;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [31:0]      time0;
    logic [ERR_W-1:0] err0;
    logic             corr0;
    logic [7:0]       time1;
    logic [ERR_W-1:0] err1;
    logic             corr1;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    exp_t last;
    longint mt = 0;
    int     me = 0;
    bit     tick_seen = 1'b0;
    bit     done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_time_accum #(.TIME_W(32), .STEP(STEP), .REM_INC(REM_INC), .DENOM(DENOM)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .time_o(time0), .err_o(err0), .corr_o(corr0));

    frac_time_accum #(.TIME_W(8), .STEP(STEP), .REM_INC(REM_INC), .DENOM(DENOM)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .time_o(time1), .err_o(err1), .corr_o(corr1));

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    always @(posedge clk) tick_seen <= rst_n ? tick : 1'b0;

    // Monitor: compare outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tick_seen) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10 scoreboard empty", 0, 1);
                end else begin
                    last = q.pop_front();
                    chk(time0 == 32'(last.t), "R2 time", time0, 32'(last.t));
                    chk(int'(err0) == last.e, "R3 remainder", err0, last.e);
                    chk(corr0 == last.c, "R4 flag", corr0, last.c);
                    chk(time1 == 8'(last.t), "R8 wrapped time", time1, 8'(last.t));
                    chk(corr1 == last.c, "R8 flag narrow", corr1, last.c);
                    chk(int'(err0) < DENOM, "R6 bound", err0, DENOM - 1);
                end
            end else begin
                chk(corr0 == 1'b0, "R5 flag idle", corr0, 0);
                chk(time0 == 32'(last.t), "R5 time hold", time0, 32'(last.t));
                chk(int'(err0) == last.e, "R5 remainder hold", err0, last.e);
            end
        end
    end

    // Driver: issue n ticks, gap idle cycles between them (0 = back to back).
    task automatic drive(input int n, input int gap);
        exp_t it;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            me = me + REM_INC;
            it.c = (me >= DENOM);
            if (it.c) me = me - DENOM;
            mt = mt + STEP + (it.c ? 1 : 0);
            it.t = mt;
            it.e = me;
            q.push_back(it);
            if (gap > 0) begin
                @(negedge clk);
                tick = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        // R1: zero while held in reset even with tick high
        chk(time0 == 0, "R1 time", time0, 0);
        chk(err0 == 0, "R1 remainder", err0, 0);
        chk(corr0 == 0, "R1 flag", corr0, 0);
        tick = 1'b0;
        q.delete();
        mt = 0;
        me = 0;
        last.t = 0;
        last.e = 0;
        last.c = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog", 0, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        last.t = 0;
        last.e = 0;
        last.c = 0;
        do_reset();
        repeat (2) @(negedge clk);
        // R7: known four-tick sequence
        drive(1, 2);
        chk(time0 == 25 && err0 == 6, "R7 tick1", time0, 25);
        drive(1, 2);
        chk(time0 == 51 && err0 == 2 && corr0 == 1'b0, "R7 tick2", time0, 51);
        drive(1, 1);
        chk(time0 == 76 && err0 == 8, "R7 tick3", time0, 76);
        drive(1, 1);
        chk(time0 == 102 && err0 == 4, "R7 tick4", time0, 102);
        // R9: one full second after DENOM ticks; R8 wraps with correction on same tick
        drive(DENOM - 4, 0);
        chk(time0 == 256 && err0 == 0, "R9 exact second", time0, 256);
        chk(time1 == 0, "R8 wrap to zero", time1, 0);
        // R10: long burst of consecutive ticks
        drive(40, 0);
        chk(time0 == 32'(mt), "R10 burst total", time0, mt);
        repeat (5) @(negedge clk);
        drive(15, 3);
        // R1: reset in mid-run
        do_reset();
        repeat (3) @(negedge clk);
        drive(23, 0);
        drive(7, 2);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule